// File: doc/BRIEF.md
# Pixel Square Plotter with Screen Clear

This block sits in front of the pixel-write port of a 160 x 120 frame buffer that holds a 3-bit colour per pixel (red, green and blue, one bit each). It takes operator commands and produces a stream of pixel writes, one per clock. Each write is a coordinate, a colour and a plot strobe. The frame buffer stores the colour at that coordinate on the next clock edge. The frame buffer, the video timing and the converters are not part of this block.

One 7-bit coordinate input serves both axes. A load command stores the input as the column, with the column's top bit forced to zero, so a square can start only in columns 0 to 127. A draw command then takes the same input as the row and paints a 4 x 4 filled square in the chosen colour, with its upper-left corner at that column and row. A clear command uses the same stepping machinery to paint the whole screen black. Commands act on their rising edge. Commands that arrive while an operation runs are ignored. A one-cycle done pulse marks the last write of each operation.

Top module: `sq_plotter`

## Requirements
- R1: A synchronous active-high reset clears the plot strobe, the done output, the stored column, the stored row and the stored colour. A draw issued after reset with no load uses column 0. Reset does not start a clear.
- R2: On a load command, the stored column becomes the 7-bit coordinate input with column bit 7 set to 0, so the stored column is at most 127.
- R3: A draw command is seen at clock edge E0. At that edge the row and colour inputs are captured. After edges E1 to E16 the outputs carry the 16 pixels of the square, one per cycle. The offset index k runs from 0 to 15. The pixel coordinate is (column + k mod 4, row + k div 4), so each row is finished before the next row starts. All 16 pixels use the captured colour.
- R4: A clear command seen at edge E0 produces 19200 consecutive writes after edges E1 to E19200, all with colour 000. The column steps from 0 to 159 inside each row, and the rows run from 0 to 119.
- R5: The done output is high for exactly one cycle, in the same cycle as the final step of a draw or a clear. It is low at all other times.
- R6: Commands act on a 0-to-1 transition. A command held high starts only one operation.
- R7: Load, draw and clear commands that rise while a draw or clear is running have no effect, either on the running operation or on the stored column.
- R8: A square pixel with column above 159 or row above 119 is not plotted: the strobe stays low for that step. The step still takes its cycle.
- R9: If several commands rise in the same idle cycle, clear wins over draw, and draw wins over load.
- R10: Squares can be drawn one after another, at new positions and in new colours, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coord_in | input | 7 | Shared coordinate input: column on load, row on draw |
| colour_in | input | 3 | Square colour, bit 2 red, bit 1 green, bit 0 blue |
| load_x_cmd | input | 1 | Load column command, acts on its rising edge |
| draw_cmd | input | 1 | Draw square command, acts on its rising edge |
| clear_cmd | input | 1 | Clear screen command, acts on its rising edge |
| pix_x | output | 8 | Column of the pixel being written |
| pix_y | output | 7 | Row of the pixel being written |
| pix_colour | output | 3 | Colour of the pixel being written |
| pix_plot | output | 1 | Pixel write strobe |
| done | output | 1 | One-cycle pulse on the final step of an operation |

## Verification
The assertions check these properties on every cycle:
- no write ever leaves the 160 x 120 area;
- writes during a clear are always black;
- the stored column, row and colour hold still while an operation runs;
- a square, once started, keeps stepping until its sixteenth offset;
- clear takes priority in an idle cycle;
- done follows only an active operation.

Only the bench's scenarios can show the following:
- the exact order of pixel coordinates;
- the total count of 19200 writes in a clear;
- clipping at the bottom edge;
- that a held command or a command during an operation really has no effect;
- that a second square uses new values.

The bench shows these by comparing every cycle against a behavioural model.

// File: rtl/sqp_pkg.sv
package sqp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SQUARE = 2'd1,
    ST_CLEAR  = 2'd2
  } sqp_state_e;

  // command bit positions in the shared command vector
  localparam int CMD_LOAD  = 0;
  localparam int CMD_DRAW  = 1;
  localparam int CMD_CLEAR = 2;
  localparam int CMD_N     = 3;
endpackage

// File: rtl/sqp_cmd_edge.sv
module sqp_cmd_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cmd,
  output logic [N-1:0] rise
);
  logic [N-1:0] cmd_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (rst) cmd_q[i] <= 1'b0;
      else     cmd_q[i] <= cmd[i];
    end
    assign rise[i] = cmd[i] & ~cmd_q[i];
  end
endmodule

// File: rtl/sqp_fsm.sv
module sqp_fsm
  import sqp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_go,
  input  logic draw_go,
  input  logic clear_go,
  input  logic sq_last,
  input  logic clr_last,
  output logic ld_x,
  output logic ld_sq,
  output logic start_clr,
  output logic step_sq,
  output logic step_clr,
  output logic busy,
  output logic done
);
  sqp_state_e state, state_nx;

  wire idle = (state == ST_IDLE);

  // priority inside an idle cycle: clear, then draw, then load
  assign start_clr = idle & clear_go;
  assign ld_sq     = idle & ~clear_go & draw_go;
  assign ld_x      = idle & ~clear_go & ~draw_go & load_go;
  assign step_sq   = (state == ST_SQUARE);
  assign step_clr  = (state == ST_CLEAR);
  assign busy      = ~idle;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (start_clr)  state_nx = ST_CLEAR;
        else if (ld_sq) state_nx = ST_SQUARE;
      end
      ST_SQUARE: if (sq_last)  state_nx = ST_IDLE;
      ST_CLEAR:  if (clr_last) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= (step_sq & sq_last) | (step_clr & clr_last);
    end
  end

  assert_done_after_op_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state) != ST_IDLE);
  assert_clear_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && clear_go) |=> state == ST_CLEAR);
  assert_square_runs_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SQUARE && !sq_last) |=> state == ST_SQUARE);
endmodule

// File: rtl/sqp_datapath.sv
module sqp_datapath #(
  parameter int XW      = 8,
  parameter int YW      = 7,
  parameter int CW      = 3,
  parameter int H_RES   = 160,
  parameter int V_RES   = 120,
  parameter int SQ_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [YW-1:0] coord_in,
  input  logic [CW-1:0] colour_in,
  input  logic          ld_x,
  input  logic          ld_sq,
  input  logic          start_clr,
  input  logic          step_sq,
  input  logic          step_clr,
  input  logic          busy,
  output logic          sq_last,
  output logic          clr_last,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic [CW-1:0] pix_colour,
  output logic          pix_plot
);
  localparam int OFFW = 2 * SQ_LOG2;
  localparam logic [OFFW-1:0] OFF_MAX  = '1;
  localparam logic [XW-1:0]   X_LAST   = XW'(H_RES - 1);
  localparam logic [YW-1:0]   Y_LAST   = YW'(V_RES - 1);
  localparam logic [XW:0]     X_LIMIT  = (XW+1)'(H_RES);
  localparam logic [YW:0]     Y_LIMIT  = (YW+1)'(V_RES);

  logic [XW-1:0]   x_reg;
  logic [YW-1:0]   y_reg;
  logic [CW-1:0]   col_reg;
  logic [OFFW-1:0] off;
  logic [XW-1:0]   cx;
  logic [YW-1:0]   cy;
  logic            clr_out;

  logic [SQ_LOG2-1:0] dx, dy;
  logic [XW:0]        sq_x;
  logic [YW:0]        sq_y;
  logic               sq_in;

  always_comb begin
    dx    = off[SQ_LOG2-1:0];
    dy    = off[OFFW-1:SQ_LOG2];
    sq_x  = {1'b0, x_reg} + (XW+1)'(dx);
    sq_y  = {1'b0, y_reg} + (YW+1)'(dy);
    sq_in = (sq_x < X_LIMIT) && (sq_y < Y_LIMIT);
  end

  assign sq_last  = (off == OFF_MAX);
  assign clr_last = (cx == X_LAST) && (cy == Y_LAST);

  // operand registers: the column is loaded from the 7-bit input, upper bits zero
  always_ff @(posedge clk) begin
    if (rst) begin
      x_reg   <= '0;
      y_reg   <= '0;
      col_reg <= '0;
    end else begin
      if (ld_x) x_reg <= XW'(coord_in);
      if (ld_sq) begin
        y_reg   <= coord_in;
        col_reg <= colour_in;
      end
    end
  end

  // square offset counter
  always_ff @(posedge clk) begin
    if (rst || ld_sq) off <= '0;
    else if (step_sq) off <= off + 1'b1;
  end

  // full-screen sweep counters, column inner
  always_ff @(posedge clk) begin
    if (rst || start_clr) begin
      cx <= '0;
      cy <= '0;
    end else if (step_clr) begin
      if (cx == X_LAST) begin
        cx <= '0;
        cy <= (cy == Y_LAST) ? '0 : cy + 1'b1;
      end else begin
        cx <= cx + 1'b1;
      end
    end
  end

  // registered pixel port
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x      <= '0;
      pix_y      <= '0;
      pix_colour <= '0;
      pix_plot   <= 1'b0;
      clr_out    <= 1'b0;
    end else begin
      clr_out <= step_clr;
      if (step_sq) begin
        pix_x      <= sq_x[XW-1:0];
        pix_y      <= sq_y[YW-1:0];
        pix_colour <= col_reg;
        pix_plot   <= sq_in;
      end else if (step_clr) begin
        pix_x      <= cx;
        pix_y      <= cy;
        pix_colour <= '0;
        pix_plot   <= 1'b1;
      end else begin
        pix_plot   <= 1'b0;
      end
    end
  end

  assert_on_screen_R8: assert property (@(posedge clk) disable iff (rst)
    pix_plot |-> (int'(pix_x) < H_RES && int'(pix_y) < V_RES));
  assert_clear_black_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_plot && clr_out) |-> pix_colour == '0);
  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(x_reg) && $stable(y_reg) && $stable(col_reg)));
endmodule

// File: rtl/sq_plotter.sv
module sq_plotter
  import sqp_pkg::*;
#(
  parameter int XW      = 8,
  parameter int YW      = 7,
  parameter int CW      = 3,
  parameter int H_RES   = 160,
  parameter int V_RES   = 120,
  parameter int SQ_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [YW-1:0] coord_in,
  input  logic [CW-1:0] colour_in,
  input  logic          load_x_cmd,
  input  logic          draw_cmd,
  input  logic          clear_cmd,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic [CW-1:0] pix_colour,
  output logic          pix_plot,
  output logic          done
);
  logic [CMD_N-1:0] cmd_vec, cmd_rise;
  logic ld_x, ld_sq, start_clr, step_sq, step_clr, busy, sq_last, clr_last;

  always_comb begin
    cmd_vec            = '0;
    cmd_vec[CMD_LOAD]  = load_x_cmd;
    cmd_vec[CMD_DRAW]  = draw_cmd;
    cmd_vec[CMD_CLEAR] = clear_cmd;
  end

  sqp_cmd_edge #(.N(CMD_N)) u_edge (
    .clk(clk), .rst(rst), .cmd(cmd_vec), .rise(cmd_rise)
  );

  sqp_fsm u_fsm (
    .clk(clk), .rst(rst),
    .load_go(cmd_rise[CMD_LOAD]), .draw_go(cmd_rise[CMD_DRAW]),
    .clear_go(cmd_rise[CMD_CLEAR]),
    .sq_last(sq_last), .clr_last(clr_last),
    .ld_x(ld_x), .ld_sq(ld_sq), .start_clr(start_clr),
    .step_sq(step_sq), .step_clr(step_clr), .busy(busy), .done(done)
  );

  sqp_datapath #(
    .XW(XW), .YW(YW), .CW(CW), .H_RES(H_RES), .V_RES(V_RES), .SQ_LOG2(SQ_LOG2)
  ) u_dp (
    .clk(clk), .rst(rst), .coord_in(coord_in), .colour_in(colour_in),
    .ld_x(ld_x), .ld_sq(ld_sq), .start_clr(start_clr),
    .step_sq(step_sq), .step_clr(step_clr), .busy(busy),
    .sq_last(sq_last), .clr_last(clr_last),
    .pix_x(pix_x), .pix_y(pix_y), .pix_colour(pix_colour), .pix_plot(pix_plot)
  );
endmodule

// File: tb/tb_sq_plotter.sv
module tb_sq_plotter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] coord_in = '0;
  logic [2:0] colour_in = '0;
  logic load_x_cmd = 1'b0, draw_cmd = 1'b0, clear_cmd = 1'b0;
  logic [7:0] pix_x;
  logic [6:0] pix_y;
  logic [2:0] pix_colour;
  logic pix_plot, done;

  always #5 clk = ~clk;

  sq_plotter dut (
    .clk(clk), .rst(rst), .coord_in(coord_in), .colour_in(colour_in),
    .load_x_cmd(load_x_cmd), .draw_cmd(draw_cmd), .clear_cmd(clear_cmd),
    .pix_x(pix_x), .pix_y(pix_y), .pix_colour(pix_colour),
    .pix_plot(pix_plot), .done(done)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural reference model, updated on every rising edge
  int m_state = 0, m_x = 0, m_y = 0, m_col = 0, m_k = 0, m_cx = 0, m_cy = 0;
  bit p_l = 0, p_d = 0, p_c = 0;
  int e_x = 0, e_y = 0, e_col = 0;
  bit e_we = 0, e_done = 0, started = 0;
  string e_tag = "R1";

  always @(posedge clk) begin
    bit le, de, ce;
    int px, py;
    started = 1;
    if (rst) begin
      m_state = 0; m_x = 0; m_y = 0; m_col = 0; m_k = 0;
      p_l = 0; p_d = 0; p_c = 0; e_we = 0; e_done = 0; e_tag = "R1";
    end else begin
      le = load_x_cmd && !p_l; de = draw_cmd && !p_d; ce = clear_cmd && !p_c;
      e_we = 0; e_done = 0;
      case (m_state)
        0: begin
          e_tag = "R6";
          if (ce) begin m_state = 2; m_cx = 0; m_cy = 0; end
          else if (de) begin m_y = coord_in; m_col = colour_in; m_k = 0; m_state = 1; end
          else if (le) m_x = coord_in;
        end
        1: begin
          px = m_x + m_k % 4; py = m_y + m_k / 4;
          e_x = px % 256; e_y = py % 128; e_col = m_col;
          e_we = (px < 160) && (py < 120);
          e_tag = e_we ? "R3" : "R8";
          if (m_k == 15) begin m_state = 0; e_done = 1; end
          m_k++;
        end
        default: begin
          e_x = m_cx; e_y = m_cy; e_col = 0; e_we = 1; e_tag = "R4";
          if (m_cx == 159) begin
            m_cx = 0;
            if (m_cy == 119) begin m_state = 0; e_done = 1; end
            else m_cy++;
          end else m_cx++;
        end
      endcase
      p_l = load_x_cmd; p_d = draw_cmd; p_c = clear_cmd;
    end
  end

  // per-cycle comparison and window counters
  int plot_cnt = 0, done_cnt = 0, first_x = -1, first_y = -1;
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (pix_plot !== e_we || done !== e_done ||
          (e_we && (pix_x !== e_x[7:0] || pix_y !== e_y[6:0] || pix_colour !== e_col[2:0]))) begin
        failures++;
        $display("FAIL %s (R5 on done) plot=%0b x=%0d y=%0d c=%0d done=%0b expected plot=%0b x=%0d y=%0d c=%0d done=%0b",
                 e_tag, pix_plot, pix_x, pix_y, pix_colour, done, e_we, e_x, e_y, e_col, e_done);
      end
      if (pix_plot) begin
        if (first_x < 0) begin first_x = pix_x; first_y = pix_y; end
        plot_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic clr_win();
    plot_cnt = 0; done_cnt = 0; first_x = -1; first_y = -1;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_load(int v);
    @(negedge clk); coord_in = v[6:0]; load_x_cmd = 1;
    @(negedge clk); load_x_cmd = 0;
  endtask

  task automatic pulse_draw(int y, int c);
    @(negedge clk); coord_in = y[6:0]; colour_in = c[2:0]; draw_cmd = 1;
    @(negedge clk); draw_cmd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    check("R1 plot in reset", int'(pix_plot), 0);
    check("R1 done in reset", int'(done), 0);
    @(negedge clk); rst = 0;
    idle(3);

    // R1: draw without load uses column 0
    clr_win(); pulse_draw(5, 1); idle(20);
    check("R1 first x", first_x, 0);
    check("R3 plots", plot_cnt, 16);
    check("R5 done count", done_cnt, 1);

    // R2/R3: load then draw in red
    pulse_load(10); clr_win(); pulse_draw(20, 4); idle(20);
    check("R2 first x", first_x, 10);
    check("R3 first y", first_y, 20);
    check("R3 plots", plot_cnt, 16);

    // R2: top column value 127
    pulse_load(127); clr_win(); pulse_draw(40, 2); idle(20);
    check("R2 max column", first_x, 127);

    // R6: held draw starts one square only
    pulse_load(30); clr_win();
    @(negedge clk); coord_in = 50; colour_in = 3; draw_cmd = 1;
    idle(40); draw_cmd = 0; idle(3);
    check("R6 held draw plots", plot_cnt, 16);
    check("R6 held draw dones", done_cnt, 1);

    // R7: commands during a square are ignored
    clr_win(); pulse_draw(60, 5);
    pulse_load(3); @(negedge clk); clear_cmd = 1; @(negedge clk); clear_cmd = 0;
    pulse_draw(1, 7); idle(20);
    check("R7 plots", plot_cnt, 16);
    check("R7 dones", done_cnt, 1);
    clr_win(); pulse_draw(70, 6); idle(20);
    check("R7 column kept", first_x, 30);

    // R8: bottom clipping, rows 118..121
    clr_win(); pulse_draw(118, 1); idle(20);
    check("R8 clipped plots", plot_cnt, 8);
    clr_win(); pulse_draw(127, 1); idle(20);
    check("R8 fully clipped", plot_cnt, 0);
    check("R5 done when clipped", done_cnt, 1);

    // R10: another square, new place and colour
    pulse_load(90); clr_win(); pulse_draw(100, 3); idle(20);
    check("R10 x", first_x, 90);
    check("R10 y", first_y, 100);

    // R9 and R4: clear and draw rise together, clear wins
    clr_win();
    @(negedge clk); coord_in = 9; colour_in = 7; clear_cmd = 1; draw_cmd = 1;
    @(negedge clk); clear_cmd = 0; draw_cmd = 0;
    idle(19210);
    check("R4 clear plots", plot_cnt, 19200);
    check("R9 first x", first_x, 0);
    check("R5 clear done", done_cnt, 1);

    // R1: reset mid-square, then no stray writes
    clr_win(); pulse_draw(10, 2); idle(4);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    clr_win(); idle(20);
    check("R1 no writes after reset", plot_cnt, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule